// File: doc/BRIEF.md
# Three-Channel Interval Timer

This peripheral holds three identical up-counters, each driven by its own power-of-two divider. All three sit behind one small register bus. A channel can run free and wrap at the top of its width, or wrap back to zero when it reaches a programmed limit. Each wrap leaves a pending flag. Any enabled flag drives that channel's interrupt line until software reads the flag register, and the read also clears the flags.

The bus is a single-cycle strobe interface with 32-bit data and word addresses. A write takes effect at the clock edge on which `bus_wr` is high. For a read, `bus_rd` is held high for one cycle and the data appears on `bus_rdata` in the following cycle. The address stride between channels is one word, so the same register of neighbouring channels sits at adjacent word addresses. Each channel can take its count events from the system clock or from a synchronous qualifier input.

Top module: `tri_interval_timer`

## Requirements
- R1: Register k of channel c sits at word address base+c. The bases are: clock setup 0, run control 3, live count 6, limit 9, pending flags 21, flag enable 24. A read returns data in the cycle after the `bus_rd` strobe. An address that maps to no register reads as 0.
- R2: After reset, on every channel, clock setup, count, limit, pending flags and flag enable all read 0, run control reads 0x1, and `irq` is low.
- R3: While run-control bit 0 is 1, the count holds its value. The edge of the write that sets bit 0 still counts.
- R4: Clock-setup bit 0 enables division, and bits 4:1 hold a value E. With division enabled the count steps once every 2^(E+1) source events. With division off it steps on every source event.
- R5: Clock-setup bit 5 picks the source. A value of 0 takes every clock cycle as an event. A value of 1 takes only cycles where `ext_tick[c]` is high. Bits 5:0 read back as written.
- R6: With run-control bit 1 at 0 (free mode), the count wraps from 2^CNT_W-1 to 0 and sets pending bit 1.
- R7: With run-control bit 1 at 1 (limit mode), a step taken while the count equals the limit returns the count to 0 and sets pending bit 0.
- R8: Writing run control with bit 4 at 1 zeroes the count and the divider phase at that edge. Bit 4 always reads as 0.
- R9: Reading the pending flags clears them. A flag event in the same cycle as the read stays pending.
- R10: Each channel's `irq` is high while any pending bit has its matching enable bit set (enable bit 0 for the limit flag, bit 1 for the wrap flag). It falls after the clearing read.
- R11: Channels are independent. Activity on one channel does not change another channel's registers or count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the strobe |
| ext_tick | input | NUM_CH | Per-channel synchronous count qualifier |
| irq | output | NUM_CH | Per-channel interrupt |

## Verification
Three kinds of internal fault show up at the ports, each at a different point. A wrong divider phase or a stepping error shows up at the next count read as a value that no longer matches the elapsed edges divided by the divisor. A lost or spurious flag is visible on `irq` one cycle after the event when the flag is enabled, and otherwise on the next flag read. A clear that races an event in the wrong direction leaves a second back-to-back flag read empty when it should still hold the flag.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // word-address bases of channel 0; channel c adds c
  localparam int unsigned BASE_CLK = 0;
  localparam int unsigned BASE_CTL = 3;
  localparam int unsigned BASE_CNT = 6;
  localparam int unsigned BASE_LIM = 9;
  localparam int unsigned BASE_PND = 21;
  localparam int unsigned BASE_IEN = 24;

  // clock setup: bit5 source, bits4:1 exponent, bit0 divide enable
  typedef struct packed {
    logic       src_ext;
    logic [3:0] div_exp;
    logic       div_en;
  } clk_cfg_t;

  // run control as stored: bit1 limit mode, bit0 halt
  typedef struct packed {
    logic lim_mode;
    logic halt;
  } run_cfg_t;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CLK, SEL_CTL, SEL_CNT, SEL_LIM, SEL_PND, SEL_IEN
  } reg_sel_e;

  // last phase value of the divider: 2^(e+1) - 1
  function automatic logic [16:0] div_last(input logic [3:0] e);
    return (17'd2 << e) - 17'd1;
  endfunction

  // which register of channel ch the word address hits
  function automatic reg_sel_e decode_reg(input int unsigned addr, input int unsigned ch);
    if (addr < ch) return SEL_NONE;
    case (addr - ch)
      BASE_CLK: return SEL_CLK;
      BASE_CTL: return SEL_CTL;
      BASE_CNT: return SEL_CNT;
      BASE_LIM: return SEL_LIM;
      BASE_PND: return SEL_PND;
      BASE_IEN: return SEL_IEN;
      default:  return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/tmr_divider.sv
module tmr_divider
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       src_evt,
  input  logic       run,
  input  logic       restart,
  input  logic       div_en,
  input  logic [3:0] div_exp,
  output logic       tick
);
  logic [15:0] phase;
  logic        at_last;

  assign at_last = ({1'b0, phase} >= div_last(div_exp));
  assign tick    = run && src_evt && (!div_en || at_last) && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (restart) begin
      phase <= '0;
    end else if (run && src_evt && div_en) begin
      phase <= at_last ? '0 : phase + 16'd1;
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic             lim_mode,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             lim_evt,
  output logic             wrap_evt
);
  localparam logic [CNT_W-1:0] TOP = '1;

  assign lim_evt  = tick && lim_mode && (count == limit);
  assign wrap_evt = tick && !lim_evt && (count == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (restart) begin
      count <= '0;
    end else if (tick) begin
      count <= (lim_evt || wrap_evt) ? '0 : count + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_evt,
  input  logic             wr_clk,
  input  logic             wr_ctl,
  input  logic             wr_lim,
  input  logic             wr_ien,
  input  logic             rd_pnd,
  input  logic [31:0]      wdata,
  output clk_cfg_t         clk_cfg,
  output run_cfg_t         run_cfg,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] limit,
  output logic [1:0]       pending,
  output logic [1:0]       flag_en,
  output logic             irq,
  output logic             tick,
  output logic             restart,
  output logic             lim_evt,
  output logic             wrap_evt
);
  logic src_evt;

  assign restart = wr_ctl && wdata[4];
  assign src_evt = clk_cfg.src_ext ? ext_evt : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_cfg <= '0;
      run_cfg <= '{lim_mode: 1'b0, halt: 1'b1};
      limit   <= '0;
      flag_en <= '0;
    end else begin
      if (wr_clk) clk_cfg <= clk_cfg_t'(wdata[5:0]);
      if (wr_ctl) run_cfg <= run_cfg_t'(wdata[1:0]);
      if (wr_lim) limit   <= wdata[CNT_W-1:0];
      if (wr_ien) flag_en <= wdata[1:0];
    end
  end

  // clear-on-read, a same-cycle event stays set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= '0;
    end else begin
      pending <= (rd_pnd ? 2'b00 : pending) | {wrap_evt, lim_evt};
    end
  end

  assign irq = |(pending & flag_en);

  tmr_divider u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_evt (src_evt),
    .run     (!run_cfg.halt),
    .restart (restart),
    .div_en  (clk_cfg.div_en),
    .div_exp (clk_cfg.div_exp),
    .tick    (tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .restart  (restart),
    .lim_mode (run_cfg.lim_mode),
    .limit    (limit),
    .count    (count),
    .lim_evt  (lim_evt),
    .wrap_evt (wrap_evt)
  );
endmodule

// File: rtl/tri_interval_timer.sv
module tri_interval_timer
  import tmr_pkg::*;
#(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NUM_CH-1:0] ext_tick,
  output logic [NUM_CH-1:0] irq
);
  clk_cfg_t [NUM_CH-1:0]              ch_clk;
  run_cfg_t [NUM_CH-1:0]              ch_run;
  logic     [NUM_CH-1:0][CNT_W-1:0]   ch_cnt;
  logic     [NUM_CH-1:0][CNT_W-1:0]   ch_lim;
  logic     [NUM_CH-1:0][1:0]         ch_pnd;
  logic     [NUM_CH-1:0][1:0]         ch_ien;
  logic     [NUM_CH-1:0]              ch_tick;
  logic     [NUM_CH-1:0]              ch_restart;
  logic     [NUM_CH-1:0]              ch_lim_evt;
  logic     [NUM_CH-1:0]              ch_wrap_evt;
  logic     [NUM_CH-1:0]              ch_rd_pnd;
  logic     [NUM_CH-1:0]              ch_halt;
  logic     [NUM_CH-1:0][31:0]        ch_rword;
  logic     [31:0]                    rd_mux;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    reg_sel_e sel;
    assign sel = decode_reg(int'(bus_addr), c);
    assign ch_rd_pnd[c] = bus_rd && (sel == SEL_PND);
    assign ch_halt[c]   = ch_run[c].halt;

    tmr_channel #(.CNT_W(CNT_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .ext_evt  (ext_tick[c]),
      .wr_clk   (bus_wr && (sel == SEL_CLK)),
      .wr_ctl   (bus_wr && (sel == SEL_CTL)),
      .wr_lim   (bus_wr && (sel == SEL_LIM)),
      .wr_ien   (bus_wr && (sel == SEL_IEN)),
      .rd_pnd   (ch_rd_pnd[c]),
      .wdata    (bus_wdata),
      .clk_cfg  (ch_clk[c]),
      .run_cfg  (ch_run[c]),
      .count    (ch_cnt[c]),
      .limit    (ch_lim[c]),
      .pending  (ch_pnd[c]),
      .flag_en  (ch_ien[c]),
      .irq      (irq[c]),
      .tick     (ch_tick[c]),
      .restart  (ch_restart[c]),
      .lim_evt  (ch_lim_evt[c]),
      .wrap_evt (ch_wrap_evt[c])
    );

    always_comb begin
      case (sel)
        SEL_CLK: ch_rword[c] = {26'd0, ch_clk[c]};
        SEL_CTL: ch_rword[c] = {30'd0, ch_run[c]};
        SEL_CNT: ch_rword[c] = 32'(ch_cnt[c]);
        SEL_LIM: ch_rword[c] = 32'(ch_lim[c]);
        SEL_PND: ch_rword[c] = {30'd0, ch_pnd[c]};
        SEL_IEN: ch_rword[c] = {30'd0, ch_ien[c]};
        default: ch_rword[c] = 32'd0;
      endcase
    end
  end

  always_comb begin
    rd_mux = 32'd0;
    for (int c = 0; c < NUM_CH; c++) rd_mux = rd_mux | ch_rword[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= 32'd0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned CNT_W  = 16
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [NUM_CH-1:0]              tick,
  input logic [NUM_CH-1:0]              restart,
  input logic [NUM_CH-1:0]              lim_evt,
  input logic [NUM_CH-1:0]              wrap_evt,
  input logic [NUM_CH-1:0]              halt,
  input logic [NUM_CH-1:0][CNT_W-1:0]   cnt,
  input logic [NUM_CH-1:0][1:0]         pnd,
  input logic [NUM_CH-1:0][1:0]         ien,
  input logic [NUM_CH-1:0]              irq
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    a_r3_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (halt[c] && !restart[c]) |=> $stable(cnt[c]));
    a_r4_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
      (tick[c] && !restart[c] && !lim_evt[c] && !wrap_evt[c]) |=> cnt[c] == $past(cnt[c]) + ONE);
    a_r6_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_evt[c] |=> cnt[c] == '0);
    a_r7_limit_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
      lim_evt[c] |=> (cnt[c] == '0 && pnd[c][0]));
    a_r8_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
      restart[c] |=> cnt[c] == '0);
    a_r9_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_evt[c] |=> pnd[c][1]);
    a_r10_irq_raised: assert property (@(posedge clk) disable iff (!rst_n)
      (lim_evt[c] && ien[c][0]) |=> irq[c]);
    a_r10_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (ien[c] == 2'b00) |-> !irq[c]);
  end
endmodule

bind tri_interval_timer tmr_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (ch_tick),
  .restart  (ch_restart),
  .lim_evt  (ch_lim_evt),
  .wrap_evt (ch_wrap_evt),
  .halt     (ch_halt),
  .cnt      (ch_cnt),
  .pnd      (ch_pnd),
  .ien      (ch_ien),
  .irq      (irq)
);

// File: tb/tri_interval_timer_bench.sv
`timescale 1ns/1ps
module tri_interval_timer_bench;
  localparam int NCH = 3;
  localparam int W   = 16;
  localparam int AW  = 6;
  localparam int A_CLK = 0, A_CTL = 3, A_CNT = 6, A_LIM = 9, A_PND = 21, A_IEN = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NCH-1:0] ext_tick = '0;
  logic [NCH-1:0] irq;

  int n_chk = 0, n_fail = 0, cyc = 0, last_edge = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tri_interval_timer #(.NUM_CH(NCH), .CNT_W(W), .ADDR_W(AW)) u_tri_interval_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_tick(ext_tick), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0; last_edge = cyc;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = AW'(a);
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0; last_edge = cyc; d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // steps seen by a read at edge er when counting restarted at edge e0
  function automatic int steps(input int e0, input int er, input int div);
    return (er - e0 - 1) / div;
  endfunction

  function automatic int exp_count(input int st, input bit lim_mode, input int lim);
    return lim_mode ? st % (lim + 1) : st % (1 << W);
  endfunction

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2;
    int e0, ed, er, es;
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: reset values on every channel
    for (int c = 0; c < NCH; c++) begin
      rd(A_CLK + c, d); chk("R2 clk", d, 0);
      rd(A_CTL + c, d); chk("R2 ctl", d, 1);
      rd(A_CNT + c, d); chk("R2 cnt", d, 0);
      rd(A_LIM + c, d); chk("R2 lim", d, 0);
      rd(A_PND + c, d); chk("R2 pnd", d, 0);
      rd(A_IEN + c, d); chk("R2 ien", d, 0);
    end
    chk("R2 irq", 32'(irq), 0);

    // R1: interleaved limits and an unmapped word
    for (int c = 0; c < NCH; c++) wr(A_LIM + c, 32'h100 + c);
    for (int c = 0; c < NCH; c++) begin rd(A_LIM + c, d); chk("R1 lim map", d, 32'h100 + c); end
    rd(30, d); chk("R1 unmapped", d, 0);

    // R8: restart bit reads back as 0
    wr(A_CTL, 32'h13); rd(A_CTL, d); chk("R8 ctl readback", d, 32'h3);
    wr(A_CTL, 32'h1);

    // R3: halt freezes the count
    wr(A_CTL, 32'h10); e0 = last_edge;
    idle(10);
    wr(A_CTL, 32'h1); ed = last_edge;
    idle(5);
    rd(A_CNT, d); chk("R3 held count", d, 32'(ed - e0));
    idle(7);
    rd(A_CNT, d2); chk("R3 still held", d2, d);

    // R11: other channels untouched
    rd(A_CNT + 2, d); chk("R11 ch2 count", d, 0);
    rd(A_LIM + 1, d); chk("R11 ch1 limit", d, 32'h101);

    // R5: external qualifier source
    wr(A_CLK + 1, 32'h20); rd(A_CLK + 1, d); chk("R5 clk readback", d, 32'h20);
    wr(A_CTL + 1, 32'h10);
    idle(4);
    ext_tick[1] = 1'b1; idle(5); ext_tick[1] = 1'b0;
    idle(3);
    rd(A_CNT + 1, d); chk("R5 ext count", d, 5);
    wr(A_CTL + 1, 32'h1); wr(A_CLK + 1, 32'h0);

    // R4: divide by 8 (exponent 2, enabled)
    wr(A_CLK, 32'h5); wr(A_CTL, 32'h10); e0 = last_edge;
    idle(40);
    rd(A_CNT, d); er = last_edge; chk("R4 div8 count", d, 32'(steps(e0, er, 8)));
    wr(A_CTL, 32'h1); wr(A_CLK, 32'h0);

    // R9: limit 0 fires every step; clear races the event
    wr(A_LIM + 2, 0); rd(A_PND + 2, d);
    wr(A_CTL + 2, 32'h12); idle(2);
    rd(A_PND + 2, d); chk("R9 pending", d, 1);
    rd(A_PND + 2, d); chk("R9 event wins", d, 1);
    wr(A_CTL + 2, 32'h3);
    rd(A_PND + 2, d); chk("R9 last event", d, 1);
    rd(A_PND + 2, d); chk("R9 cleared", d, 0);

    // R10: interrupt follows enabled flags
    wr(A_IEN + 2, 1); rd(A_IEN + 2, d); chk("R10 ien readback", d, 1);
    wr(A_CTL + 2, 32'h12); idle(3);
    chk("R10 irq high", 32'(irq[2]), 1);
    chk("R10 other irq low", 32'(irq[0]), 0);
    wr(A_CTL + 2, 32'h3);
    rd(A_PND + 2, d);
    chk("R10 irq after clear", 32'(irq[2]), 0);
    wr(A_IEN + 2, 2); wr(A_CTL + 2, 32'h12); idle(3);
    chk("R10 masked flag", 32'(irq[2]), 0);
    wr(A_CTL + 2, 32'h3); rd(A_PND + 2, d);

    // R6: free-mode wrap at the top of the width
    wr(A_CTL + 1, 32'h10); e0 = last_edge;
    idle((1 << W) + 4);
    rd(A_CNT + 1, d); er = last_edge;
    chk("R6 wrapped count", d, 32'(exp_count(steps(e0, er, 1), 1'b0, 0)));
    rd(A_PND + 1, d); chk("R6 wrap flag", d, 2);
    wr(A_CTL + 1, 32'h1); rd(A_PND + 1, d);

    // R7/R4: random channel, mode, divider and limit
    for (int it = 0; it < 24; it++) begin
      int c, n, lim, wt, div;
      bit md, pe;
      c   = $urandom_range(0, NCH - 1);
      md  = 1'($urandom_range(0, 1));
      pe  = 1'($urandom_range(0, 1));
      n   = $urandom_range(0, 2);
      lim = $urandom_range(0, 12);
      wt  = $urandom_range(0, 40);
      div = pe ? (2 << n) : 1;
      wr(A_CTL + c, 32'h1);
      rd(A_PND + c, d);
      wr(A_LIM + c, lim);
      wr(A_CLK + c, (n << 1) | pe);
      wr(A_CTL + c, 32'h10 | (md << 1)); e0 = last_edge;
      idle(wt);
      rd(A_CNT + c, d); er = last_edge;
      chk("R7 random count", d, 32'(exp_count(steps(e0, er, div), md, lim)));
      rd(A_PND + c, d); es = last_edge;
      chk("R7 random flag", d, (md && steps(e0, es, div) >= lim + 1) ? 1 : 0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule